// File: doc/BRIEF.md
# SMBus Packet Error Code Byte Counter

This block runs alongside an I2C byte shifter and looks after the SMBus Packet Error Code (PEC) of each transfer. Every byte that crosses the bus, address bytes included, is folded into a running CRC-8. Only payload bytes are counted. The CRC value is always visible at an output, so it can be read as an 8-bit status value.

When the payload count equals a programmed size and automatic PEC handling is enabled, the block enters a PEC phase on its own, with no help from software. In transmit direction it asks the shifter to send the PEC byte, which is the current CRC value. In receive direction it treats the next payload byte as the PEC byte. In both directions the PEC byte is folded into the CRC and a done flag is raised. On receive, an error flag is raised when the CRC is not zero after the PEC byte has been folded in.

The shifter reports a START (or repeated START) and a STOP with single-cycle pulses. These pulses reset the count and the CRC, which starts again from zero.

Top module: `smb_pec_engine`

## Requirements
- R1: After reset, `crc_o` is 0x00 and `pec_req_o`, `done_o` and `err_o` are 0.
- R2: Each accepted byte, address or data, updates the CRC one cycle later. The CRC uses the polynomial x^8+x^2+x+1 (0x07), starts at 0x00 and takes the byte MSB first.
- R3: While `pec_en` is 0, the block ignores every byte strobe. The CRC, the count and both flags are cleared and stay cleared.
- R4: A `start_i` pulse or a `stop_i` pulse clears the CRC and the payload count. This clear takes priority over a byte strobe in the same cycle, and that byte is dropped.
- R5: Bytes with `addr_i`=1 are not counted. The PEC phase holds when four conditions are all true: at least one address byte has been seen since the last clear, `pec_tx_en` is 1, the count equals `size_i`, and `done_o` is 0. `pec_req_o` is 1 exactly in the PEC phase while `rx_i`=0.
- R6: Transmit (`rx_i`=0): the first data byte in the PEC phase is the PEC byte. It is folded into the CRC, `done_o` rises, `pec_req_o` falls and `err_o` stays 0.
- R7: Receive (`rx_i`=1): the first data byte in the PEC phase is folded into the CRC and `done_o` rises. `err_o` rises in the same cycle if and only if the resulting CRC is not 0x00.
- R8: While `done_o` is 1, the block ignores byte strobes and the CRC does not change.
- R9: With `pec_tx_en`=0 there is no PEC phase, and the payload count saturates at 2^SIZE_W-1. If `pec_tx_en` is raised later, the phase is entered as soon as the count equals `size_i`.
- R10: With `size_i`=0, the PEC phase is entered right after the first address byte.
- R11: `done_o` and `err_o` are kept through a STOP. They are cleared by `start_i` or by `pec_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pec_en | input | 1 | Enables PEC calculation |
| pec_tx_en | input | 1 | Enables automatic PEC send/check at the programmed size |
| size_i | input | SIZE_W | Payload byte count before the PEC byte |
| start_i | input | 1 | Pulse on START or repeated START |
| stop_i | input | 1 | Pulse on STOP |
| rx_i | input | 1 | 1 = block receives data bytes, 0 = block transmits |
| byte_vld_i | input | 1 | A byte completed on the bus this cycle |
| addr_i | input | 1 | The completed byte is an address byte |
| byte_i | input | 8 | Byte value |
| crc_o | output | 8 | Running CRC-8 (the PEC value) |
| pec_req_o | output | 1 | Request to transmit the PEC byte |
| done_o | output | 1 | PEC phase complete |
| err_o | output | 1 | Received PEC did not match |

## Verification
The bench builds the block with SIZE_W=4. This reduces the size field to sixteen values, so every payload size from 0 to 15 can be run as a full frame in both directions, with correct and with corrupted PEC bytes. The narrow counter also lets a short frame reach the saturation limit. The table-based CRC variant is selected, and its output for all 256 single-byte frames is compared with a bit-serial reference CRC computed in the bench.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;

   localparam int CRC_W = 8;

   typedef logic [CRC_W-1:0] crc_t;

   // One byte folded into the CRC, whole byte xored in first, then 8 shifts.
   function automatic crc_t crc8_step(input crc_t c_in, input crc_t d_in, input crc_t poly);
      crc_t c;
      c = c_in ^ d_in;
      for (int k = 0; k < CRC_W; k++) begin
         if (c[CRC_W-1]) c = (c << 1) ^ poly;
         else            c = c << 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/smb_pec_crc8.sv
module smb_pec_crc8
   import smb_pec_pkg::*;
#(
   parameter logic [7:0] POLY = 8'h07,
   parameter int         IMPL = 0      // 0: bitwise loop, 1: 256-entry table
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic upd_i,
   input  crc_t byte_i,
   output crc_t crc_o,
   output crc_t nxt_o
);

   localparam int TBL_N = 1 << CRC_W;

   crc_t crc_q;

   initial begin
      assert (IMPL == 0 || IMPL == 1) else $error("IMPL must be 0 or 1");
      assert (POLY[0] == 1'b1) else $error("POLY must have its x^0 term");
   end

   generate
      if (IMPL == 0) begin : g_loop
         assign nxt_o = crc8_step(crc_q, byte_i, POLY);
      end else begin : g_table
         crc_t tbl [TBL_N];
         always_comb begin
            for (int i = 0; i < TBL_N; i++)
               tbl[i] = crc8_step('0, crc_t'(i), POLY);
         end
         assign nxt_o = tbl[crc_q ^ byte_i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= '0;
      else if (clr_i)  crc_q <= '0;
      else if (upd_i)  crc_q <= nxt_o;
   end

   assign crc_o = crc_q;

   // R2: the CRC moves only on an update or a clear
   assert_crc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !upd_i) |=> $stable(crc_q));

   // R4: a clear always lands on zero
   assert_crc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (crc_q == '0));

endmodule

// File: rtl/smb_pec_count.sv
module smb_pec_count #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q;

   initial begin
      assert (W >= 1 && W <= 16) else $error("counter width out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (clr_i)                    cnt_q <= '0;
      else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R9: the count never wraps from its ceiling
   assert_cnt_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

   // R4: a clear always returns the count to zero
   assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine
   import smb_pec_pkg::*;
#(
   parameter int         SIZE_W   = 9,
   parameter logic [7:0] POLY     = 8'h07,
   parameter int         CRC_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pec_en,
   input  logic              pec_tx_en,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rx_i,
   input  logic              byte_vld_i,
   input  logic              addr_i,
   input  logic [7:0]        byte_i,
   output logic [7:0]        crc_o,
   output logic              pec_req_o,
   output logic              done_o,
   output logic              err_o
);

   logic              clr_frame;   // clears count and CRC
   logic              clr_flags;   // clears done and error
   logic              take;        // byte accepted this cycle
   logic              in_phase;
   logic              seen_q;
   logic              done_q;
   logic              err_q;
   logic [SIZE_W-1:0] cnt;
   crc_t              crc_nxt;

   initial begin
      assert (SIZE_W >= 1 && SIZE_W <= 16) else $error("SIZE_W out of range");
   end

   assign clr_frame = start_i | stop_i | !pec_en;
   assign clr_flags = start_i | !pec_en;
   assign take      = byte_vld_i && !clr_frame && !done_q;
   assign in_phase  = seen_q && pec_tx_en && (cnt == size_i) && !done_q;

   smb_pec_crc8 #(.POLY(POLY), .IMPL(CRC_IMPL)) i_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_frame),
      .upd_i  (take),
      .byte_i (byte_i),
      .crc_o  (crc_o),
      .nxt_o  (crc_nxt)
   );

   smb_pec_count #(.W(SIZE_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr_frame),
      .inc_i (take && !addr_i && !in_phase),
      .cnt_o (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
      end else if (clr_frame) begin
         seen_q <= 1'b0;
      end else if (take && addr_i) begin
         seen_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (clr_flags) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (take && !addr_i && in_phase) begin
         done_q <= 1'b1;
         err_q  <= rx_i && (crc_nxt != '0);
      end
   end

   assign pec_req_o = in_phase && !rx_i;
   assign done_o    = done_q;
   assign err_o     = err_q;

   // R7: an error is only ever reported together with done
   assert_err_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   // R6: done rises only in response to a byte
   assert_done_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(byte_vld_i));

   // R6: no send request once the PEC phase has finished
   assert_req_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !pec_req_o);

   // R3: disabling clears CRC and flags
   assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pec_en |=> (crc_o == 8'h00 && !done_o && !err_o));

   // R8: CRC frozen while done, unless the frame is cleared
   assert_frozen_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !clr_frame) |=> $stable(crc_o));

   // R11: a STOP alone keeps done
   assert_done_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !clr_flags) |=> done_o);

endmodule

// File: tb/test_smb_pec_engine.sv
module test_smb_pec_engine;

   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pec_en = 1'b0;
   logic          pec_tx_en = 1'b0;
   logic [SW-1:0] size_i = '0;
   logic          start_i = 1'b0;
   logic          stop_i = 1'b0;
   logic          rx_i = 1'b0;
   logic          byte_vld_i = 1'b0;
   logic          addr_i = 1'b0;
   logic [7:0]    byte_i = '0;
   logic [7:0]    crc_o;
   logic          pec_req_o;
   logic          done_o;
   logic          err_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   smb_pec_engine #(.SIZE_W(SW), .POLY(8'h07), .CRC_IMPL(1)) i_smb_pec_engine (
      .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .pec_tx_en(pec_tx_en),
      .size_i(size_i), .start_i(start_i), .stop_i(stop_i), .rx_i(rx_i),
      .byte_vld_i(byte_vld_i), .addr_i(addr_i), .byte_i(byte_i),
      .crc_o(crc_o), .pec_req_o(pec_req_o), .done_o(done_o), .err_o(err_o)
   );

   // Bit-serial reference: feedback per input bit, MSB first.
   function automatic logic [7:0] ref_crc(input logic [7:0] c_in, input logic [7:0] d);
      logic [7:0] c;
      logic fb;
      c = c_in;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0};
         if (fb) c = c ^ 8'h07;
      end
      return c;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d, input logic is_addr);
      @(negedge clk);
      byte_vld_i = 1'b1; addr_i = is_addr; byte_i = d;
      @(negedge clk);
      byte_vld_i = 1'b0; addr_i = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
   endtask

   // One full frame: address, sz payload bytes, then the PEC byte.
   task automatic run_frame(input int sz, input logic rx, input logic corrupt);
      logic [7:0] c;
      logic [7:0] pb;
      logic [7:0] addr;
      size_i = SW'(sz);
      rx_i = rx;
      pulse_start();
      chk("R4 crc after start", crc_o, 8'h00);
      addr = 8'hA0 | {7'd0, rx};
      send(addr, 1'b1);
      c = ref_crc(8'h00, addr);
      chk("R2 crc after address", crc_o, c);
      if (sz == 0) chk("R10 req on size zero", pec_req_o, !rx);
      for (int k = 0; k < sz; k++) begin
         chk("R5 no req before size", pec_req_o, 1'b0);
         pb = 8'((k * 37) + (sz * 11) + 3);
         send(pb, 1'b0);
         c = ref_crc(c, pb);
      end
      chk("R2 crc after payload", crc_o, c);
      chk("R5 req at size", pec_req_o, !rx);
      chk("R5 no done before pec", done_o, 1'b0);
      pb = c ^ (corrupt ? 8'h5A : 8'h00);
      send(pb, 1'b0);
      c = ref_crc(c, pb);
      chk(rx ? "R7 done" : "R6 done", done_o, 1'b1);
      chk(rx ? "R7 err" : "R6 err", err_o, rx && (c != 8'h00));
      chk("R6 req dropped", pec_req_o, 1'b0);
      chk("R2 crc after pec", crc_o, c);
      send(8'h3C, 1'b0);
      chk("R8 crc frozen", crc_o, c);
      pulse_stop();
      chk("R11 done kept over stop", done_o, 1'b1);
      chk("R11 err kept over stop", err_o, rx && (c != 8'h00));
      chk("R4 crc cleared by stop", crc_o, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 crc reset", crc_o, 8'h00);
      chk("R1 req reset", pec_req_o, 1'b0);
      chk("R1 done reset", done_o, 1'b0);
      chk("R1 err reset", err_o, 1'b0);
      rst_n = 1'b1;

      // R3: disabled block ignores bytes
      size_i = 4'd15;
      send(8'hFF, 1'b1);
      chk("R3 crc stays zero", crc_o, 8'h00);
      pec_en = 1'b1;

      // R2: all 256 single-byte CRCs
      pec_tx_en = 1'b1;
      for (int b = 0; b < 256; b++) begin
         pulse_start();
         send(8'(b), 1'b1);
         chk("R2 single byte crc", crc_o, ref_crc(8'h00, 8'(b)));
      end

      // R4: start in the same cycle as a byte drops the byte
      @(negedge clk);
      start_i = 1'b1; byte_vld_i = 1'b1; addr_i = 1'b1; byte_i = 8'h55;
      @(negedge clk);
      start_i = 1'b0; byte_vld_i = 1'b0; addr_i = 1'b0;
      chk("R4 start wins over byte", crc_o, 8'h00);

      // R5 R6 R7 R8 R10 R11: all sizes, both directions
      for (int s = 0; s < 16; s++) begin
         run_frame(s, 1'b0, 1'b0);
         run_frame(s, 1'b1, 1'b0);
         run_frame(s, 1'b1, 1'b1);
      end

      // R11: start clears flags
      pulse_start();
      chk("R11 start clears done", done_o, 1'b0);
      chk("R11 start clears err", err_o, 1'b0);

      // R9: saturation with auto PEC off, then raised
      pec_tx_en = 1'b0;
      size_i = 4'd15;
      rx_i = 1'b0;
      send(8'hA0, 1'b1);
      for (int k = 0; k < 20; k++) send(8'(k), 1'b0);
      chk("R9 no req while off", pec_req_o, 1'b0);
      pec_tx_en = 1'b1;
      #1;
      chk("R9 req after saturation", pec_req_o, 1'b1);

      // R3: dropping enable clears the flags
      send(8'h11, 1'b0);
      chk("R6 done before disable", done_o, 1'b1);
      @(negedge clk); pec_en = 1'b0;
      @(negedge clk);
      chk("R3 disable clears done", done_o, 1'b0);
      chk("R3 disable clears crc", crc_o, 8'h00);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule